// File: doc/BRIEF.md
# Dual Token-Bucket Rate Shaper

This block holds two byte-credit buckets for one traffic flow: a committed bucket and a peak bucket. Each bucket has its own parameter set. The refill rate is given as a mantissa and two exponents. Every `tick * 2^down` clock cycles the bucket gains `base * 2^up` bytes of credit. The size of the bucket is given as a mantissa and a shift, and means `bs_base * 2^bs_shift` kilobytes. The tick comes from a shaper-level selector, which is shared by both buckets.

A requester shows a packet length with a valid/ready handshake. The block raises ready when every bucket that enforces a rate holds credit of zero or more. A transfer happens in a cycle where both valid and ready are high, and the packet length is then taken from each enforcing bucket. A credit may go below zero; the flow is then held back until refills bring the credit back to zero or above. A bucket whose rate fields (base, up and down) are all zero does not limit traffic. It keeps its credit at full size and takes no deduction. A committed bucket left at zero rate is the normal setting, so that only the peak bucket enforces the rate.

Top module: `dual_bucket_shaper`

## Requirements
- R1: After reset, `req_ready` is high. Both rate fields are zero and both bucket sizes are base 1, shift 4, so both credits read 16384 bytes.
- R2: In a cycle with `cfg_wr` high, `req_ready` is low and no transfer takes place. At the next edge, each bucket's credit becomes its new size `bs_base << (bs_shift + 10)` bytes, and its refill timer restarts.
- R3: An enforcing bucket gains `base << up` bytes exactly once every `tick << down` cycles. The first refill lands `tick << down` edges after the configuring edge.
- R4: The tick comes from `cfg_level`, as latched at configuration: 0 gives 1536, 1 gives 192, 2 gives 48 and 3 gives 1536 cycles.
- R5: A refill never raises a credit above its bucket size; the credit saturates at that size.
- R6: `req_ready` is high exactly when every enforcing bucket holds a non-negative credit (and `cfg_wr` is low).
- R7: On a transfer, `req_len` is subtracted from each enforcing bucket, and the result may be negative.
- R8: A bucket whose base, up and down are all zero never limits `req_ready`, and its credit stays at its size whatever transfers occur.
- R9: When a refill and a transfer fall in the same cycle, the new credit is `min(credit + base << up, size) - req_len`.
- R10: A cycle with no transfer and no refill leaves both credits unchanged. This holds when `req_valid` is high while `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Load all parameter fields in this cycle |
| cfg_level | input | 2 | Shaper level, which selects the tick (0 priority, 1 group, 2 port, 3 queue set) |
| cir_base | input | 8 | Committed bucket: refill mantissa |
| cir_up | input | 4 | Committed bucket: refill amount exponent |
| cir_down | input | 4 | Committed bucket: refill period exponent |
| cir_bs_base | input | 8 | Committed bucket: size mantissa in kilobytes |
| cir_bs_shift | input | 4 | Committed bucket: size exponent |
| pir_base | input | 8 | Peak bucket: refill mantissa |
| pir_up | input | 4 | Peak bucket: refill amount exponent |
| pir_down | input | 4 | Peak bucket: refill period exponent |
| pir_bs_base | input | 8 | Peak bucket: size mantissa in kilobytes |
| pir_bs_shift | input | 4 | Peak bucket: size exponent |
| req_valid | input | 1 | A packet is waiting to go |
| req_len | input | 16 | Packet length in bytes |
| req_ready | output | 1 | The packet may go in this cycle |
| cir_credit | output | 40 | Committed bucket credit in bytes, signed |
| pir_credit | output | 40 | Peak bucket credit in bytes, signed |

## Verification
A refill and a deduction can land on the same clock edge, and the order in which they apply decides whether saturation cuts credit away. The bench provokes this by first letting the peak bucket fill to its size. It then holds a stream of one-byte packets valid for many refill periods, so that transfers are granted on the very cycles the refill timer fires. A reference model applies refill, then saturation, then deduction on every edge, and the credits and ready are compared each cycle. A design that deducts first and saturates afterwards shows a larger credit on those cycles.

// File: rtl/shp_pkg.sv
`timescale 1ns/1ps
package shp_pkg;
   typedef enum logic [1:0] {
      LVL_PRIO  = 2'd0,
      LVL_GROUP = 2'd1,
      LVL_PORT  = 2'd2,
      LVL_QSET  = 2'd3
   } shp_level_e;

   localparam int NUM_BUCKETS = 2;
   localparam int BKT_CIR     = 0;
   localparam int BKT_PIR     = 1;
endpackage

// File: rtl/shp_refill_timer.sv
`timescale 1ns/1ps
module shp_refill_timer
   import shp_pkg::*;
#(
   parameter int CNT_W      = 32,
   parameter int EXP_W      = 4,
   parameter int TICK_PRIO  = 1536,
   parameter int TICK_GROUP = 192,
   parameter int TICK_PORT  = 48,
   parameter int TICK_QSET  = 1536
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  shp_level_e       level,
   input  logic [EXP_W-1:0] down,
   output logic             fire
);
   logic [CNT_W-1:0] tick_sel;
   logic [CNT_W-1:0] period;
   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      unique case (level)
         LVL_PRIO:  tick_sel = CNT_W'(TICK_PRIO);
         LVL_GROUP: tick_sel = CNT_W'(TICK_GROUP);
         LVL_PORT:  tick_sel = CNT_W'(TICK_PORT);
         default:   tick_sel = CNT_W'(TICK_QSET);
      endcase
   end

   assign period = tick_sel << down;
   assign fire   = (cnt_q == period - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart || fire) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/shp_bucket.sv
`timescale 1ns/1ps
module shp_bucket
   import shp_pkg::*;
#(
   parameter int BASE_W       = 8,
   parameter int EXP_W        = 4,
   parameter int LEN_W        = 16,
   parameter int CRED_W       = 40,
   parameter int CNT_W        = 32,
   parameter int KB_SHIFT     = 10,
   parameter int DEF_BS_BASE  = 1,
   parameter int DEF_BS_SHIFT = 4,
   parameter int TICK_PRIO    = 1536,
   parameter int TICK_GROUP   = 192,
   parameter int TICK_PORT    = 48,
   parameter int TICK_QSET    = 1536
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  shp_level_e               level,
   input  logic [BASE_W-1:0]        cfg_base,
   input  logic [EXP_W-1:0]         cfg_up,
   input  logic [EXP_W-1:0]         cfg_down,
   input  logic [BASE_W-1:0]        cfg_bs_base,
   input  logic [EXP_W-1:0]         cfg_bs_shift,
   input  logic                     take,
   input  logic [LEN_W-1:0]         len,
   output logic signed [CRED_W-1:0] credit,
   output logic                     ok,
   output logic                     fire,
   output logic                     bypass
);
   localparam logic [CRED_W-1:0] DEF_CAP =
      CRED_W'(DEF_BS_BASE) << (DEF_BS_SHIFT + KB_SHIFT);

   function automatic logic [CRED_W-1:0] bucket_size(
      input logic [BASE_W-1:0] bsb,
      input logic [EXP_W-1:0]  bss
   );
      return CRED_W'(bsb) << (32'(bss) + KB_SHIFT);
   endfunction

   logic [BASE_W-1:0]        base_q;
   logic [EXP_W-1:0]         up_q;
   logic [EXP_W-1:0]         down_q;
   logic [CRED_W-1:0]        cap_q;
   logic signed [CRED_W-1:0] credit_q;
   logic signed [CRED_W-1:0] amt;
   logic signed [CRED_W-1:0] sum;
   logic signed [CRED_W-1:0] filled;
   logic signed [CRED_W-1:0] after;

   shp_refill_timer #(
      .CNT_W      (CNT_W),
      .EXP_W      (EXP_W),
      .TICK_PRIO  (TICK_PRIO),
      .TICK_GROUP (TICK_GROUP),
      .TICK_PORT  (TICK_PORT),
      .TICK_QSET  (TICK_QSET)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (load),
      .level   (level),
      .down    (down_q),
      .fire    (fire)
   );

   assign bypass = (base_q == '0) && (up_q == '0) && (down_q == '0);
   assign ok     = bypass || !credit_q[CRED_W-1];
   assign credit = credit_q;

   // refill, clamp to size, then deduct the granted packet
   always_comb begin
      amt    = $signed(CRED_W'(base_q) << up_q);
      sum    = credit_q + amt;
      filled = credit_q;
      if (fire) begin
         filled = (sum > $signed(cap_q)) ? $signed(cap_q) : sum;
      end
      after = filled;
      if (take) begin
         after = filled - $signed(CRED_W'(len));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= '0;
         up_q     <= '0;
         down_q   <= '0;
         cap_q    <= DEF_CAP;
         credit_q <= $signed(DEF_CAP);
      end else if (load) begin
         base_q   <= cfg_base;
         up_q     <= cfg_up;
         down_q   <= cfg_down;
         cap_q    <= bucket_size(cfg_bs_base, cfg_bs_shift);
         credit_q <= $signed(bucket_size(cfg_bs_base, cfg_bs_shift));
      end else if (!bypass) begin
         credit_q <= after;
      end
   end
endmodule

// File: rtl/dual_bucket_shaper.sv
`timescale 1ns/1ps
module dual_bucket_shaper
   import shp_pkg::*;
#(
   parameter int BASE_W       = 8,
   parameter int EXP_W        = 4,
   parameter int LEN_W        = 16,
   parameter int CRED_W       = 40,
   parameter int CNT_W        = 32,
   parameter int KB_SHIFT     = 10,
   parameter int DEF_BS_BASE  = 1,
   parameter int DEF_BS_SHIFT = 4,
   parameter int TICK_PRIO    = 1536,
   parameter int TICK_GROUP   = 192,
   parameter int TICK_PORT    = 48,
   parameter int TICK_QSET    = 1536
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_wr,
   input  logic [1:0]               cfg_level,
   input  logic [BASE_W-1:0]        cir_base,
   input  logic [EXP_W-1:0]         cir_up,
   input  logic [EXP_W-1:0]         cir_down,
   input  logic [BASE_W-1:0]        cir_bs_base,
   input  logic [EXP_W-1:0]         cir_bs_shift,
   input  logic [BASE_W-1:0]        pir_base,
   input  logic [EXP_W-1:0]         pir_up,
   input  logic [EXP_W-1:0]         pir_down,
   input  logic [BASE_W-1:0]        pir_bs_base,
   input  logic [EXP_W-1:0]         pir_bs_shift,
   input  logic                     req_valid,
   input  logic [LEN_W-1:0]         req_len,
   output logic                     req_ready,
   output logic signed [CRED_W-1:0] cir_credit,
   output logic signed [CRED_W-1:0] pir_credit
);
   localparam int MAX_EXP   = (1 << EXP_W) - 1;
   localparam int CRED_NEED = BASE_W + MAX_EXP + KB_SHIFT + 2;
   localparam int MAX_TICK  = (TICK_PRIO > TICK_QSET) ? TICK_PRIO : TICK_QSET;
   localparam int CNT_NEED  = $clog2(MAX_TICK + 1) + MAX_EXP;

   if (CRED_W < CRED_NEED) begin : g_bad_cred
      $error("CRED_W too narrow for the largest bucket size");
   end
   if (LEN_W + 1 >= CRED_W) begin : g_bad_len
      $error("LEN_W must be well below CRED_W");
   end
   if (CNT_W < CNT_NEED) begin : g_bad_cnt
      $error("CNT_W too narrow for the longest refill period");
   end
   if (DEF_BS_SHIFT > MAX_EXP || DEF_BS_BASE >= (1 << BASE_W)) begin : g_bad_def
      $error("default bucket size does not fit its fields");
   end

   shp_level_e level_q;

   logic [BASE_W-1:0]        base_in   [NUM_BUCKETS];
   logic [EXP_W-1:0]         up_in     [NUM_BUCKETS];
   logic [EXP_W-1:0]         down_in   [NUM_BUCKETS];
   logic [BASE_W-1:0]        bsb_in    [NUM_BUCKETS];
   logic [EXP_W-1:0]         bss_in    [NUM_BUCKETS];
   logic signed [CRED_W-1:0] cred_vec  [NUM_BUCKETS];
   logic [NUM_BUCKETS-1:0]   ok_vec;
   logic [NUM_BUCKETS-1:0]   fire_vec;
   logic [NUM_BUCKETS-1:0]   bypass_vec;
   logic                     take;

   assign base_in[BKT_CIR] = cir_base;
   assign up_in[BKT_CIR]   = cir_up;
   assign down_in[BKT_CIR] = cir_down;
   assign bsb_in[BKT_CIR]  = cir_bs_base;
   assign bss_in[BKT_CIR]  = cir_bs_shift;
   assign base_in[BKT_PIR] = pir_base;
   assign up_in[BKT_PIR]   = pir_up;
   assign down_in[BKT_PIR] = pir_down;
   assign bsb_in[BKT_PIR]  = pir_bs_base;
   assign bss_in[BKT_PIR]  = pir_bs_shift;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= LVL_PRIO;
      end else if (cfg_wr) begin
         level_q <= shp_level_e'(cfg_level);
      end
   end

   for (genvar b = 0; b < NUM_BUCKETS; b++) begin : g_bkt
      shp_bucket #(
         .BASE_W       (BASE_W),
         .EXP_W        (EXP_W),
         .LEN_W        (LEN_W),
         .CRED_W       (CRED_W),
         .CNT_W        (CNT_W),
         .KB_SHIFT     (KB_SHIFT),
         .DEF_BS_BASE  (DEF_BS_BASE),
         .DEF_BS_SHIFT (DEF_BS_SHIFT),
         .TICK_PRIO    (TICK_PRIO),
         .TICK_GROUP   (TICK_GROUP),
         .TICK_PORT    (TICK_PORT),
         .TICK_QSET    (TICK_QSET)
      ) u_bucket (
         .clk          (clk),
         .rst_n        (rst_n),
         .load         (cfg_wr),
         .level        (level_q),
         .cfg_base     (base_in[b]),
         .cfg_up       (up_in[b]),
         .cfg_down     (down_in[b]),
         .cfg_bs_base  (bsb_in[b]),
         .cfg_bs_shift (bss_in[b]),
         .take         (take),
         .len          (req_len),
         .credit       (cred_vec[b]),
         .ok           (ok_vec[b]),
         .fire         (fire_vec[b]),
         .bypass       (bypass_vec[b])
      );
   end

   assign req_ready  = !cfg_wr && (&ok_vec);
   assign take       = req_valid && req_ready;
   assign cir_credit = cred_vec[BKT_CIR];
   assign pir_credit = cred_vec[BKT_PIR];
endmodule

// File: rtl/dual_bucket_shaper_chk.sv
`timescale 1ns/1ps
module dual_bucket_shaper_chk #(
   parameter int CRED_W = 40,
   parameter int LEN_W  = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     cfg_wr,
   input logic                     req_valid,
   input logic                     req_ready,
   input logic [LEN_W-1:0]         req_len,
   input logic signed [CRED_W-1:0] cir_credit,
   input logic signed [CRED_W-1:0] pir_credit,
   input logic [1:0]               fire_vec,
   input logic [1:0]               bypass_vec
);
   // R2: configuration cycle blocks any transfer
   a_r2_cfg_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |-> !req_ready);

   // R6: a negative enforcing peak credit holds the requester off
   a_r6_pir_neg_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass_vec[1] && pir_credit[CRED_W-1]) |-> !req_ready);

   // R6: same for the committed bucket
   a_r6_cir_neg_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass_vec[0] && cir_credit[CRED_W-1]) |-> !req_ready);

   // R7: a transfer without refill lowers the peak credit by the length
   a_r7_deduct: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !bypass_vec[1] && !fire_vec[1])
      |=> (pir_credit == $past(pir_credit)
           - $signed({{(CRED_W-LEN_W){1'b0}}, $past(req_len)})));

   // R8: a zero-rate committed bucket keeps its credit
   a_r8_bypass_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bypass_vec[0] && !cfg_wr) |=> $stable(cir_credit));

   // R10: no transfer and no refill leaves the peak credit alone
   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_wr && !(req_valid && req_ready) && !fire_vec[1])
      |=> $stable(pir_credit));
endmodule

bind dual_bucket_shaper dual_bucket_shaper_chk #(
   .CRED_W (CRED_W),
   .LEN_W  (LEN_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_wr     (cfg_wr),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_len    (req_len),
   .cir_credit (cir_credit),
   .pir_credit (pir_credit),
   .fire_vec   (fire_vec),
   .bypass_vec (bypass_vec)
);

// File: tb/sim_dual_bucket_shaper.sv
`timescale 1ns/1ps
module sim_dual_bucket_shaper;
   localparam int CRED_W = 40;
   localparam int LEN_W  = 16;

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic                     cfg_wr = 1'b0;
   logic [1:0]               cfg_level = '0;
   logic [7:0]               cir_base = '0, pir_base = '0;
   logic [3:0]               cir_up = '0, cir_down = '0, pir_up = '0, pir_down = '0;
   logic [7:0]               cir_bs_base = '0, pir_bs_base = '0;
   logic [3:0]               cir_bs_shift = '0, pir_bs_shift = '0;
   logic                     req_valid = 1'b0;
   logic [LEN_W-1:0]         req_len = '0;
   logic                     req_ready;
   logic signed [CRED_W-1:0] cir_credit, pir_credit;

   always #2.5 clk = ~clk;

   dual_bucket_shaper u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_level(cfg_level),
      .cir_base(cir_base), .cir_up(cir_up), .cir_down(cir_down),
      .cir_bs_base(cir_bs_base), .cir_bs_shift(cir_bs_shift),
      .pir_base(pir_base), .pir_up(pir_up), .pir_down(pir_down),
      .pir_bs_base(pir_bs_base), .pir_bs_shift(pir_bs_shift),
      .req_valid(req_valid), .req_len(req_len), .req_ready(req_ready),
      .cir_credit(cir_credit), .pir_credit(pir_credit)
   );

   typedef struct {
      longint c;
      longint p;
      bit     r;
      string  tag;
   } exp_t;

   exp_t   sb[$];
   event   mon_ev;
   int     n_chk = 0;
   int     n_fail = 0;
   bit     done = 0;

   // reference model state, built from the requirements
   longint mcred[2], mcap[2], mamt[2];
   int     mper[2], mcnt[2];
   bit     mbyp[2];

   function automatic int tick_of(int lvl);
      case (lvl)
         0: return 1536;
         1: return 192;
         2: return 48;
         default: return 1536;
      endcase
   endfunction

   function automatic bit m_ready();
      return (mbyp[0] || mcred[0] >= 0) && (mbyp[1] || mcred[1] >= 0);
   endfunction

   function automatic void push_exp(bit rdy, string tag);
      exp_t e;
      e.c = mcred[0]; e.p = mcred[1]; e.r = rdy; e.tag = tag;
      sb.push_back(e);
   endfunction

   // monitor: pops expected items and compares with the ports
   initial begin
      forever begin
         @(mon_ev);
         while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (longint'(cir_credit) != e.c || longint'(pir_credit) != e.p
                || req_ready != e.r) begin
               n_fail++;
               $display("FAIL %s: cir=%0d pir=%0d rdy=%0b expected cir=%0d pir=%0d rdy=%0b",
                        e.tag, longint'(cir_credit), longint'(pir_credit), req_ready,
                        e.c, e.p, e.r);
            end
         end
      end
   end

   // one clock of traffic: check before the edge, then advance the model
   task automatic step(input bit v, input int len, input string tag);
      bit g;
      req_valid = v;
      req_len   = LEN_W'(len);
      #0.5;
      push_exp(m_ready(), tag);
      -> mon_ev;
      #0.5;
      g = v && m_ready();
      for (int b = 0; b < 2; b++) begin
         bit f;
         f = (mcnt[b] == mper[b] - 1);
         if (!mbyp[b]) begin
            if (f) begin
               mcred[b] = mcred[b] + mamt[b];
               if (mcred[b] > mcap[b]) mcred[b] = mcap[b];
            end
            if (g) mcred[b] = mcred[b] - len;
         end
         mcnt[b] = f ? 0 : mcnt[b] + 1;
      end
      @(negedge clk);
   endtask

   task automatic configure(input int lvl,
                            input int cb, input int cu, input int cd,
                            input int cbb, input int cbs,
                            input int pb, input int pu, input int pd,
                            input int pbb, input int pbs,
                            input string tag);
      cfg_level = 2'(lvl);
      cir_base = 8'(cb); cir_up = 4'(cu); cir_down = 4'(cd);
      cir_bs_base = 8'(cbb); cir_bs_shift = 4'(cbs);
      pir_base = 8'(pb); pir_up = 4'(pu); pir_down = 4'(pd);
      pir_bs_base = 8'(pbb); pir_bs_shift = 4'(pbs);
      cfg_wr = 1'b1;
      req_valid = 1'b1;
      req_len = LEN_W'(5);
      #0.5;
      push_exp(1'b0, tag);
      -> mon_ev;
      #0.5;
      mcap[0] = longint'(cbb) << (cbs + 10);
      mcap[1] = longint'(pbb) << (pbs + 10);
      mamt[0] = longint'(cb) << cu;
      mamt[1] = longint'(pb) << pu;
      mper[0] = tick_of(lvl) << cd;
      mper[1] = tick_of(lvl) << pd;
      mbyp[0] = (cb == 0 && cu == 0 && cd == 0);
      mbyp[1] = (pb == 0 && pu == 0 && pd == 0);
      for (int b = 0; b < 2; b++) begin
         mcred[b] = mcap[b];
         mcnt[b]  = 0;
      end
      @(negedge clk);
      cfg_wr = 1'b0;
      req_valid = 1'b0;
   endtask

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not end, actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int b = 0; b < 2; b++) begin
         mcred[b] = 16384; mcap[b] = 16384; mamt[b] = 0;
         mper[b] = 1536; mcnt[b] = 0; mbyp[b] = 1;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      step(0, 0, "R1");
      // R8: both buckets at zero rate pass traffic untouched
      repeat (3) step(1, 1000, "R8");

      // R2 / R4: port level, peak rate 200 bytes per 96 cycles, 2 KB sizes
      configure(2, 0, 0, 0, 2, 0, 100, 1, 1, 1, 1, "R2");
      repeat (10) step(0, 0, "R10");
      step(1, 1500, "R7");
      step(1, 600, "R7");
      // R6: valid held while credit negative, ready returns after refill
      repeat (150) step(1, 700, "R6");
      // R5: long idle fills to the bucket size and stops there
      repeat (1200) step(0, 0, "R5");
      // R9: grants coincide with refills while the bucket is full
      repeat (300) step(1, 1, "R9");
      // R3: drain then watch refills arrive every period
      step(1, 2000, "R3");
      repeat (300) step(0, 0, "R3");

      // R4: each level's tick, peak adds 1 byte per tick, 1 KB size
      for (int l = 0; l < 4; l++) begin
         configure(l, 0, 0, 0, 1, 0, 1, 0, 0, 1, 0, "R4");
         step(1, 1030, "R4");
         repeat (2 * tick_of(l) + 3) step(1, 1, "R4");
      end

      // R6: committed bucket enforcing and blocking while peak has credit
      configure(2, 10, 0, 0, 1, 0, 50, 0, 0, 4, 0, "R6");
      step(1, 1100, "R6");
      repeat (400) step(1, 100, "R6");
      // R2: reconfigure with valid high, sizes reload
      configure(1, 0, 0, 0, 3, 2, 7, 2, 0, 2, 3, "R2");
      repeat (20) step(1, 900, "R7");

      done = 1;
      #1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule